// File: doc/BRIEF.md
# Interleaved Sum and Sum-of-Squares Accumulator

This block takes a stream of unsigned Q16.16 sample values, one per clock cycle, and builds two totals per batch: the plain sum of the values and the sum of their squares. A downstream unit uses the two totals to derive the mean and variance of the batch.

The adder that updates a running total is modelled with a pipeline latency of several cycles. A single feedback register could therefore accept only one value every few cycles. To keep up a rate of one value per cycle, accepted samples are dealt in rotation across sixteen partial-total lanes. A lane is revisited only after sixteen acceptances, by which time its previous update has been written back. A sample marked as the last of its batch starts the end-of-batch sequence. The pipeline first drains. Then a pipelined binary adder tree folds the sixteen lanes into final totals, and a single output strobe presents them. The lanes are cleared as the fold starts, so the next batch begins from zero.

Top module: `sumsq_accum`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: When `out_valid` is 1, `out_sum` equals the exact sum of every `in_data` value accepted in the batch, as an unsigned integer of the raw 32-bit codes.
- R3: When `out_valid` is 1, `out_sumsq` equals the exact sum of the full 64-bit products `in_data*in_data` of every accepted value in the batch.
- R4: A batch of fewer than 16 samples, including a batch of one sample, produces correct totals. Unused lanes contribute zero.
- R5: While `in_ready` is 1, a sample is accepted on every cycle with `in_valid` high, including back-to-back cycles. Cycles with `in_valid` low add nothing to the totals.
- R6: `out_valid` is a one-cycle pulse that rises exactly 8 clock edges after the edge that accepts the sample with `in_last` high. The 8 edges are 4 for the adder drain and 4 for the fold tree.
- R7: `in_ready` is 0 from the edge that accepts the last sample until the edge after the `out_valid` cycle. Samples offered in that window are ignored.
- R8: Each batch starts from zero totals. Nothing from an earlier batch carries over.
- R9: `out_sum` and `out_sumsq` hold their values after the pulse until the next batch's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present |
| in_last | input | 1 | Sample closes the batch |
| in_data | input | 32 | Unsigned Q16.16 sample |
| in_ready | output | 1 | Block accepts samples this cycle |
| out_valid | output | 1 | One-cycle result strobe |
| out_sum | output | 52 | Batch sum of values |
| out_sumsq | output | 84 | Batch sum of squared values |

## Verification
The assertions assume that a batch never holds more than 2^20 samples. They also assume that `in_last` only means something together with `in_valid`, so an empty batch cannot occur. The stimulus keeps batches below a few hundred samples, always closes each batch with a valid last sample, and mixes random bubbles, all-ones and all-zero values and sub-16 sizes. It also drives valid samples with random `in_last` while `in_ready` is low. This shows that samples offered during the drain and fold never leak into the next batch.

// File: rtl/sumsq_pkg.sv
package sumsq_pkg;
    localparam int LANES   = 16;  // interleave depth, power of two
    localparam int IN_W    = 32;  // Q16.16 sample
    localparam int MAX_LOG = 20;  // log2 of largest batch
    localparam int ADD_LAT = 4;   // modelled adder latency

    localparam int IDX_W = $clog2(LANES);
    localparam int SUM_W = IN_W + MAX_LOG;
    localparam int SQ_W  = 2 * IN_W + MAX_LOG;

    typedef enum logic [1:0] {
        PH_COLLECT = 2'd0,
        PH_DRAIN   = 2'd1,
        PH_FOLD    = 2'd2
    } phase_e;
endpackage

// File: rtl/interleave_bank.sv
module interleave_bank #(
    parameter int N   = 16,
    parameter int W   = 52,
    parameter int LAT = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          add_en,
    input  logic [IW-1:0] add_idx,
    input  logic [W-1:0]  addend,
    output logic [W-1:0]  bank [N]
);
    logic [LAT-1:0] pv;
    logic [IW-1:0]  pidx [LAT];
    logic [W-1:0]   pval [LAT];

    // adder modelled as a LAT-deep pipeline: result reaches the lane LAT edges later
    always_ff @(posedge clk) begin
        if (rst) begin
            pv <= '0;
        end else begin
            pv[0] <= add_en;
            for (int s = 1; s < LAT; s++) pv[s] <= pv[s-1];
        end
        pidx[0] <= add_idx;
        pval[0] <= bank[add_idx] + addend;
        for (int s = 1; s < LAT; s++) begin
            pidx[s] <= pidx[s-1];
            pval[s] <= pval[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < N; i++) bank[i] <= '0;
        end else if (pv[LAT-1]) begin
            bank[pidx[LAT-1]] <= pval[LAT-1];
        end
    end

    // R5: a lane being read is never the one whose update is just landing
    a_r5_no_lane_hazard: assert property (@(posedge clk) disable iff (rst)
        (add_en && pv[LAT-1]) |-> (pidx[LAT-1] != add_idx));

    // R8: lanes are only cleared once nothing is in flight
    a_r8_clear_when_drained: assert property (@(posedge clk) disable iff (rst)
        clr |-> (pv == '0 && !add_en));
endmodule

// File: rtl/fold_tree.sv
module fold_tree #(
    parameter int N = 16,
    parameter int W = 52,
    localparam int LV = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] leaves [N],
    output logic [W-1:0] total,
    output logic         done
);
    logic [W-1:0]  node [LV+1][N];
    logic [LV-1:0] vsh;
    logic [LV:1]   ld;

    always_ff @(posedge clk) begin
        if (rst) vsh <= '0;
        else     vsh <= (vsh << 1) | LV'(go);
    end

    for (genvar j = 0; j < N; j++) begin : g_leaf
        assign node[0][j] = leaves[j];
    end

    for (genvar l = 1; l <= LV; l++) begin : g_lvl
        if (l == 1) begin : g_first
            assign ld[l] = go;
        end else begin : g_next
            assign ld[l] = vsh[l-2];
        end
        for (genvar j = 0; j < N; j++) begin : g_node
            if (j < (N >> l)) begin : g_add
                always_ff @(posedge clk) begin
                    if (rst)        node[l][j] <= '0;
                    else if (ld[l]) node[l][j] <= node[l-1][2*j] + node[l-1][2*j+1];
                end
            end else begin : g_pad
                assign node[l][j] = '0;
            end
        end
    end

    assign total = node[LV][0];
    assign done  = vsh[LV-1];

    // R9: the result register only moves when a fold completes
    a_r9_total_held: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(total) || $past(rst));
endmodule

// File: rtl/sumsq_accum.sv
module sumsq_accum #(
    parameter int LANES   = sumsq_pkg::LANES,
    parameter int IN_W    = sumsq_pkg::IN_W,
    parameter int MAX_LOG = sumsq_pkg::MAX_LOG,
    parameter int ADD_LAT = sumsq_pkg::ADD_LAT,
    localparam int IDX_W  = $clog2(LANES),
    localparam int SUM_W  = IN_W + MAX_LOG,
    localparam int SQ_W   = 2 * IN_W + MAX_LOG,
    localparam int CNT_W  = $clog2(ADD_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [IN_W-1:0]  in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [SUM_W-1:0] out_sum,
    output logic [SQ_W-1:0]  out_sumsq
);
    import sumsq_pkg::*;

    phase_e           phase;
    logic [IDX_W-1:0] lane;
    logic [CNT_W-1:0] cnt;
    logic             accept, go, done_s, done_q;
    logic [2*IN_W-1:0] square;
    logic [SUM_W-1:0] sum_lanes [LANES];
    logic [SQ_W-1:0]  sq_lanes  [LANES];

    assign in_ready = (phase == PH_COLLECT);
    assign accept   = in_valid && in_ready;
    assign go       = (phase == PH_DRAIN) && (cnt == CNT_W'(ADD_LAT));
    assign square   = (2*IN_W)'(in_data) * (2*IN_W)'(in_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_COLLECT;
            lane  <= '0;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_COLLECT: if (accept) begin
                    lane <= lane + IDX_W'(1);
                    if (in_last) begin
                        phase <= PH_DRAIN;
                        cnt   <= '0;
                        lane  <= '0;
                    end
                end
                PH_DRAIN: begin
                    cnt <= cnt + CNT_W'(1);
                    if (go) phase <= PH_FOLD;
                end
                PH_FOLD: if (done_s) phase <= PH_COLLECT;
                default: phase <= PH_COLLECT;
            endcase
        end
    end

    interleave_bank #(.N(LANES), .W(SUM_W), .LAT(ADD_LAT)) u_sum_bank (
        .clk(clk), .rst(rst), .clr(go), .add_en(accept), .add_idx(lane),
        .addend(SUM_W'(in_data)), .bank(sum_lanes));

    interleave_bank #(.N(LANES), .W(SQ_W), .LAT(ADD_LAT)) u_sq_bank (
        .clk(clk), .rst(rst), .clr(go), .add_en(accept), .add_idx(lane),
        .addend(SQ_W'(square)), .bank(sq_lanes));

    fold_tree #(.N(LANES), .W(SUM_W)) u_sum_tree (
        .clk(clk), .rst(rst), .go(go), .leaves(sum_lanes),
        .total(out_sum), .done(done_s));

    fold_tree #(.N(LANES), .W(SQ_W)) u_sq_tree (
        .clk(clk), .rst(rst), .go(go), .leaves(sq_lanes),
        .total(out_sumsq), .done(done_q));

    assign out_valid = done_s;

    // R1: first cycle out of reset
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_valid));

    // R6: both folds finish together and the strobe lasts one cycle
    a_r6_trees_aligned: assert property (@(posedge clk) disable iff (rst)
        done_s == done_q);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R7: intake closes after the last sample and reopens after the strobe
    a_r7_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (accept && in_last) |=> !in_ready);
    a_r7_ready_returns: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> in_ready);
endmodule

// File: tb/tb_sumsq_accum.sv
module tb_sumsq_accum;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic         clk = 0;
    logic         rst;
    logic         in_valid, in_last;
    logic [31:0]  in_data;
    logic         in_ready, out_valid;
    logic [51:0]  out_sum;
    logic [83:0]  out_sumsq;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sumsq_accum dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
        .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
        .out_sum(out_sum), .out_sumsq(out_sumsq));

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pick(input int kind);
        case (kind)
            1:       return 32'hFFFF_FFFF;
            2:       return 32'h0;
            3:       return {16'h0, $urandom_range(65535)};  // small values
            default: return $urandom();
        endcase
    endfunction

    task automatic run_batch(input int n, input int kind, input int gap_pct);
        logic [127:0] es = '0;
        logic [127:0] eq = '0;
        logic [31:0]  v;
        for (int i = 0; i < n; i++) begin
            while (gap_pct > 0 && $urandom_range(99) < gap_pct) begin
                @(negedge clk);
                in_valid = 0;
                in_data  = $urandom();   // R5: bubble data must not count
                in_last  = $urandom_range(1);
            end
            @(negedge clk);
            chk(in_ready == 1'b1, "R5 ready during batch", 128'(in_ready), 128'd1);
            v = pick(kind);
            in_valid = 1;
            in_data  = v;
            in_last  = (i == n - 1);
            es += 128'(v);
            eq += 128'(v) * 128'(v);
        end
        for (int j = 0; j <= 9; j++) begin
            @(negedge clk);
            if (j == 0)
                chk(in_ready == 1'b0, "R7 ready low after last", 128'(in_ready), 128'd0);
            if (j == 7)
                chk(out_valid == 1'b0, "R6 no early strobe", 128'(out_valid), 128'd0);
            if (j == 8) begin
                chk(out_valid == 1'b1, "R6 strobe at 8 edges", 128'(out_valid), 128'd1);
                chk(128'(out_sum) == es, "R2 sum", 128'(out_sum), es);
                chk(128'(out_sumsq) == eq, "R3 sum of squares", 128'(out_sumsq), eq);
                if (n < 16)
                    chk(128'(out_sum) == es, "R4 short batch", 128'(out_sum), es);
            end
            if (j == 9) begin
                chk(out_valid == 1'b0, "R6 single pulse", 128'(out_valid), 128'd0);
                chk(in_ready == 1'b1, "R7 ready returns", 128'(in_ready), 128'd1);
                chk(128'(out_sum) == es && 128'(out_sumsq) == eq,
                    "R9 totals held", 128'(out_sum), es);
            end
            // R7/R8: samples offered while busy must be dropped
            in_valid = (j <= 8);
            in_data  = 32'hDEAD_BEEF ^ $urandom();
            in_last  = $urandom_range(1);
        end
        in_valid = 0;
        in_last  = 0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1; in_valid = 0; in_last = 0; in_data = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready after reset", 128'(in_ready), 128'd1);
        chk(out_valid == 1'b0, "R1 no strobe after reset", 128'(out_valid), 128'd0);

        run_batch(1, 0, 0);     // R4 single sample
        run_batch(2, 3, 0);     // R4
        run_batch(15, 0, 0);    // R4 one lane unused
        run_batch(16, 1, 0);    // all lanes once, max code
        run_batch(17, 0, 0);    // lane 0 revisited
        run_batch(40, 2, 0);    // all zero, R8 after nonzero batches
        run_batch(64, 1, 0);    // max code, four full rotations
        run_batch(33, 0, 40);   // R5 bubbles
        for (int k = 0; k < 12; k++)
            run_batch($urandom_range(1, 300), $urandom_range(0, 3), $urandom_range(0, 30));
        run_batch(5, 0, 60);    // R4 with heavy bubbles

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule